// File: doc/BRIEF.md
# Nested-Loop Multichannel DMA Engine

This block moves words between locations of one shared memory on behalf of a set of independent channels. Each channel holds a descriptor that describes two nested loops. The inner loop is a burst of word transfers. The outer loop counts how many times that burst must run. Every transfer is a read of one word at the source address, followed by a write of that same word to the destination address. After each transfer, both addresses step by signed offsets taken from the descriptor.

A channel runs one inner loop each time it is activated. Software can activate it with a start pulse. Another channel can also activate it through a link, which fires when that other channel finishes an inner loop or finishes its outer loop. Pending channels share a single transfer engine. The engine picks the next channel by fixed priority or by round robin, and it runs the chosen inner loop to its end without preemption. When the outer loop ends, the channel sets a done flag and can raise an interrupt. If scatter/gather is enabled, the engine then fetches a fresh descriptor from memory.

The memory side is a valid/ready request port. The engine raises `mem_valid` and holds the address, direction and write data steady until the memory answers with `mem_ready`. Memory can stall the engine for any number of cycles by keeping `mem_ready` low. Read data is taken in the cycle where `mem_valid` and `mem_ready` are both high.

Top module: `loopdma`

## Requirements
- R1: After reset, `done_o`, `irq_o` and `mem_valid` are all zero. A descriptor is written with `cfg_we` and holds three words, all addresses and offsets in word units:
  - w0: source address in [15:0], destination address in [31:16].
  - w1: signed source offset in [7:0], signed destination offset in [15:8], inner count in [23:16] (at least 1), outer count in [31:24].
  - w2: next-descriptor address in [15:0], link channel in [19:16], inner-end link enable in bit 28, outer-end link enable in bit 29, interrupt enable in bit 30, scatter/gather enable in bit 31.
- R2: Each transfer reads the word at the current source address, then writes that word to the current destination address. After each transfer the source address steps by the source offset and the destination address by the destination offset. The addresses carry over from one inner loop to the next.
- R3: One activation performs exactly the inner count of transfers, then lowers the remaining outer count by one.
- R4: A one-cycle pulse on `sw_start[c]` activates channel c.
- R5: Activating a channel whose remaining outer count is zero produces no memory access.
- R6: With `rr_mode`=0, the highest-numbered pending channel is granted.
- R7: With `rr_mode`=1, the search starts at the channel after the last one granted and wraps around. After reset, the last granted channel counts as NCH-1.
- R8: `done_o[c]` rises when channel c's remaining outer count reaches zero, and it stays high until a `done_clr[c]` pulse. `irq_o[c]` rises together with done only if the interrupt enable is set. `done_clr[c]` clears both.
- R9: If the inner-end link enable is set, an inner loop that leaves the outer count above zero activates the link channel.
- R10: If the outer-end link enable is set, the inner loop that brings the outer count to zero activates the link channel, and the inner-end link does not fire for that loop.
- R11: If scatter/gather is enabled, outer-loop completion reads the words at next-descriptor address +0, +1 and +2 as w0, w1 and w2, and installs them as the channel's descriptor with the outer count reloaded.
- R12: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged and `mem_valid` stays high.
- R13: A running inner loop completes before any other channel is granted, even one of higher priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_mode | input | 1 | 0: fixed priority, 1: round robin |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_ch | input | $clog2(NCH) | Channel whose descriptor is written |
| cfg_w0 | input | 32 | Descriptor word 0 |
| cfg_w1 | input | 32 | Descriptor word 1 |
| cfg_w2 | input | 32 | Descriptor word 2 |
| sw_start | input | NCH | Software activation pulses |
| done_clr | input | NCH | Done and interrupt clear pulses |
| done_o | output | NCH | Outer loop finished, per channel |
| irq_o | output | NCH | Interrupt request, per channel |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts or answers the request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |

## Verification
The bench builds the block with NCH=4 against a 256-word memory whose ready line stalls on a pseudo-random pattern. Four channels are few enough that every fixed-priority and round-robin ordering can be predicted and checked in full, and that link chains and a scatter/gather reload fit in a short run. The outer sweep covers every combination of source offset (+1, +2, -1), destination offset (+1, -1), inner count (1 to 3) and outer count (1 to 2). For each combination the bench computes every destination word from the known source pattern.

// File: rtl/loopdma_pkg.sv
package loopdma_pkg;
  localparam int AW   = 16;
  localparam int DW   = 32;
  localparam int CNTW = 8;
  localparam int OFFW = 8;
  localparam int LNKW = 4;

  typedef struct packed {
    logic [AW-1:0]          src;
    logic [AW-1:0]          dst;
    logic signed [OFFW-1:0] soff;
    logic signed [OFFW-1:0] doff;
    logic [CNTW-1:0]        inner;
    logic [CNTW-1:0]        outer;
    logic                   sg_en;
    logic                   int_en;
    logic                   lnk_out_en;
    logic                   lnk_in_en;
    logic [LNKW-1:0]        lnk_ch;
    logic [AW-1:0]          nxt_addr;
  } desc_t;

  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN, ST_SG} eng_st_e;

  function automatic desc_t words_to_desc(input logic [DW-1:0] w0,
                                          input logic [DW-1:0] w1,
                                          input logic [DW-1:0] w2);
    desc_t d;
    d.src        = w0[15:0];
    d.dst        = w0[31:16];
    d.soff       = w1[7:0];
    d.doff       = w1[15:8];
    d.inner      = w1[23:16];
    d.outer      = w1[31:24];
    d.nxt_addr   = w2[15:0];
    d.lnk_ch     = w2[19:16];
    d.lnk_in_en  = w2[28];
    d.lnk_out_en = w2[29];
    d.int_en     = w2[30];
    d.sg_en      = w2[31];
    return d;
  endfunction
endpackage

// File: rtl/loopdma_chan.sv
module loopdma_chan
  import loopdma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  desc_t           load_desc,
  input  logic            wb_en,
  input  logic [AW-1:0]   wb_src,
  input  logic [AW-1:0]   wb_dst,
  input  logic            start,
  input  logic            grant,
  input  logic            clr,
  output desc_t           desc,
  output logic [CNTW-1:0] remain,
  output logic            pending,
  output logic            done,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc    <= '0;
      remain  <= '0;
      pending <= 1'b0;
      done    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (load) begin
        desc   <= load_desc;
        remain <= load_desc.outer;
      end else if (wb_en) begin
        desc.src <= wb_src;
        desc.dst <= wb_dst;
        remain   <= remain - 1'b1;
      end

      if (wb_en && remain == 1) begin
        done <= 1'b1;
        if (desc.int_en) irq <= 1'b1;
      end else if (clr) begin
        done <= 1'b0;
        irq  <= 1'b0;
      end

      if (start)      pending <= 1'b1;
      else if (grant) pending <= 1'b0;
    end
  end

  a_r8_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> remain == 0);
  a_r8_irq_has_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
endmodule

// File: rtl/loopdma_arb.sv
module loopdma_arb #(
  parameter int NCH = 16,
  localparam int LW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rr_mode,
  input  logic [NCH-1:0] pend,
  input  logic           take,
  output logic           gnt_vld,
  output logic [LW-1:0]  gnt_idx
);
  logic [LW-1:0] last_q;

  always_comb begin
    gnt_vld = |pend;
    gnt_idx = '0;
    if (!rr_mode) begin
      for (int i = 0; i < NCH; i++)
        if (pend[i]) gnt_idx = LW'(i);
    end else begin
      for (int k = NCH - 1; k >= 0; k--)
        if (pend[(int'(last_q) + 1 + k) % NCH])
          gnt_idx = LW'((int'(last_q) + 1 + k) % NCH);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= LW'(NCH - 1);
    else if (take) last_q <= gnt_idx;
  end

  a_r6_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && !rr_mode) |-> (pend >> gnt_idx) == NCH'(1));
  a_r7_rr_next: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && rr_mode && pend[(int'(last_q) + 1) % NCH]) |->
      gnt_idx == LW'((int'(last_q) + 1) % NCH));
endmodule

// File: rtl/loopdma_eng.sv
module loopdma_eng
  import loopdma_pkg::*;
#(
  parameter int NCH = 16,
  localparam int LW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gnt_vld,
  input  logic [LW-1:0]   gnt_idx,
  input  desc_t           gnt_desc,
  input  logic [CNTW-1:0] gnt_remain,
  output logic            take,
  output logic [LW-1:0]   cur_ch,
  output logic            wb_en,
  output logic [AW-1:0]   wb_src,
  output logic [AW-1:0]   wb_dst,
  output logic            lnk_vld,
  output logic [LNKW-1:0] lnk_ch,
  output logic            sg_load,
  output desc_t           sg_desc,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);
  eng_st_e                st;
  logic [AW-1:0]          src_q, dst_q, nxt_q;
  logic signed [OFFW-1:0] soff_q, doff_q;
  logic [CNTW-1:0]        cnt_q, remain_q;
  logic                   sg_q, lin_q, lout_q;
  logic [LNKW-1:0]        lch_q;
  logic [DW-1:0]          data_q, w0_q, w1_q;
  logic [1:0]             sgk_q;
  logic [LW-1:0]          ch_q;
  logic                   last_loop;

  assign last_loop = (remain_q == 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      nxt_q    <= '0;
      soff_q   <= '0;
      doff_q   <= '0;
      cnt_q    <= '0;
      remain_q <= '0;
      sg_q     <= 1'b0;
      lin_q    <= 1'b0;
      lout_q   <= 1'b0;
      lch_q    <= '0;
      data_q   <= '0;
      w0_q     <= '0;
      w1_q     <= '0;
      sgk_q    <= '0;
      ch_q     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (gnt_vld) begin
          ch_q <= gnt_idx;
          if (gnt_remain != 0) begin
            src_q    <= gnt_desc.src;
            dst_q    <= gnt_desc.dst;
            soff_q   <= gnt_desc.soff;
            doff_q   <= gnt_desc.doff;
            cnt_q    <= gnt_desc.inner;
            remain_q <= gnt_remain;
            sg_q     <= gnt_desc.sg_en;
            lin_q    <= gnt_desc.lnk_in_en;
            lout_q   <= gnt_desc.lnk_out_en;
            lch_q    <= gnt_desc.lnk_ch;
            nxt_q    <= gnt_desc.nxt_addr;
            st       <= ST_RD;
          end
        end
        ST_RD: if (mem_ready) begin
          data_q <= mem_rdata;
          src_q  <= src_q + {{(AW-OFFW){soff_q[OFFW-1]}}, soff_q};
          st     <= ST_WR;
        end
        ST_WR: if (mem_ready) begin
          dst_q <= dst_q + {{(AW-OFFW){doff_q[OFFW-1]}}, doff_q};
          if (cnt_q <= 1) st <= ST_FIN;
          else begin
            cnt_q <= cnt_q - 1'b1;
            st    <= ST_RD;
          end
        end
        ST_FIN: begin
          if (last_loop && sg_q) begin
            sgk_q <= '0;
            st    <= ST_SG;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_SG: if (mem_ready) begin
          if (sgk_q == 2'd0) w0_q <= mem_rdata;
          if (sgk_q == 2'd1) w1_q <= mem_rdata;
          sgk_q <= sgk_q + 1'b1;
          if (sgk_q == 2'd2) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign take      = (st == ST_IDLE) && gnt_vld;
  assign cur_ch    = ch_q;
  assign wb_en     = (st == ST_FIN);
  assign wb_src    = src_q;
  assign wb_dst    = dst_q;
  assign lnk_vld   = wb_en && (last_loop ? lout_q : lin_q);
  assign lnk_ch    = lch_q;
  assign sg_load   = (st == ST_SG) && mem_ready && (sgk_q == 2'd2);
  assign sg_desc   = words_to_desc(w0_q, w1_q, mem_rdata);
  assign mem_valid = (st == ST_RD) || (st == ST_WR) || (st == ST_SG);
  assign mem_we    = (st == ST_WR);
  assign mem_addr  = (st == ST_WR) ? dst_q :
                     (st == ST_SG) ? nxt_q + AW'(sgk_q) : src_q;
  assign mem_wdata = data_q;

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));
  a_r2_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD && mem_ready) |=> (mem_valid && mem_we));
  a_r13_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |-> !take);
endmodule

// File: rtl/loopdma.sv
module loopdma
  import loopdma_pkg::*;
#(
  parameter int NCH = 16,
  localparam int LW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rr_mode,
  input  logic           cfg_we,
  input  logic [LW-1:0]  cfg_ch,
  input  logic [31:0]    cfg_w0,
  input  logic [31:0]    cfg_w1,
  input  logic [31:0]    cfg_w2,
  input  logic [NCH-1:0] sw_start,
  input  logic [NCH-1:0] done_clr,
  output logic [NCH-1:0] done_o,
  output logic [NCH-1:0] irq_o,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_we,
  output logic [15:0]    mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata
);
  desc_t           descs  [NCH];
  logic [CNTW-1:0] remains[NCH];
  logic [NCH-1:0]  pend;
  logic            gnt_vld, take, wb_en, lnk_vld, sg_load;
  logic [LW-1:0]   gnt_idx, cur_ch;
  logic [AW-1:0]   wb_src, wb_dst;
  logic [LNKW-1:0] lnk_ch;
  desc_t           sg_desc, cfg_desc;

  assign cfg_desc = words_to_desc(cfg_w0, cfg_w1, cfg_w2);

  loopdma_arb #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .pend(pend),
    .take(take), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  loopdma_eng #(.NCH(NCH)) u_eng (
    .clk(clk), .rst_n(rst_n), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx),
    .gnt_desc(descs[gnt_idx]), .gnt_remain(remains[gnt_idx]),
    .take(take), .cur_ch(cur_ch), .wb_en(wb_en), .wb_src(wb_src),
    .wb_dst(wb_dst), .lnk_vld(lnk_vld), .lnk_ch(lnk_ch),
    .sg_load(sg_load), .sg_desc(sg_desc), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic  here_sg, here_cfg, here_lnk;
    assign here_sg  = sg_load && (cur_ch == LW'(c));
    assign here_cfg = cfg_we && (cfg_ch == LW'(c));
    assign here_lnk = lnk_vld && (lnk_ch[LW-1:0] == LW'(c));

    loopdma_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .load(here_sg || here_cfg),
      .load_desc(here_sg ? sg_desc : cfg_desc),
      .wb_en(wb_en && (cur_ch == LW'(c))),
      .wb_src(wb_src), .wb_dst(wb_dst),
      .start(sw_start[c] || here_lnk),
      .grant(take && (gnt_idx == LW'(c))),
      .clr(done_clr[c]),
      .desc(descs[c]), .remain(remains[c]),
      .pending(pend[c]), .done(done_o[c]), .irq(irq_o[c])
    );
  end

  a_r6_grant_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend[gnt_idx]);
  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> (!mem_valid && done_o == '0 && irq_o == '0));
endmodule

// File: tb/loopdma_tb.sv
module loopdma_tb;
  localparam int NCH = 4;
  logic clk = 1'b0, rst_n = 1'b0, rr_mode = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic [31:0] cfg_w0 = '0, cfg_w1 = '0, cfg_w2 = '0;
  logic [NCH-1:0] sw_start = '0, done_clr = '0, done_o, irq_o;
  logic mem_valid, mem_ready = 1'b1, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] mem [256];
  logic [7:0]  wlog [256];
  int wcnt = 0, acnt = 0, total = 0, bad = 0;
  logic [7:0] lfsr = 8'h5B;
  bit finished = 0;

  always #4 clk = ~clk;

  loopdma #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .cfg_we(cfg_we),
    .cfg_ch(cfg_ch), .cfg_w0(cfg_w0), .cfg_w1(cfg_w1), .cfg_w2(cfg_w2),
    .sw_start(sw_start), .done_clr(done_clr), .done_o(done_o),
    .irq_o(irq_o), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      acnt = acnt + 1;
      if (mem_we) begin
        mem[mem_addr[7:0]] = mem_wdata;
        wlog[wcnt[7:0]] = mem_addr[7:0];
        wcnt = wcnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= lfsr[0] | lfsr[2];
  end

  function automatic logic [31:0] pat(input int a);
    return 32'h5A00_0000 + 32'(a) * 32'd7 + (32'(a) << 16);
  endfunction

  function automatic logic [31:0] w1f(input int so, input int dof, input int inn, input int out);
    return {8'(out), 8'(inn), 8'(dof), 8'(so)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic prog(input int ch, input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_w0 = a; cfg_w1 = b; cfg_w2 = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic kick(input logic [NCH-1:0] m);
    @(negedge clk); sw_start = m;
    @(negedge clk); sw_start = '0;
  endtask

  task automatic clear(input int ch);
    @(negedge clk); done_clr = NCH'(1) << ch;
    @(negedge clk); done_clr = '0;
  endtask

  task automatic pause(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ncase, w0c, a0, sa, da, exp_last;
    for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? pat(i) : 32'd0;
    pause(3);
    check(done_o == 0 && irq_o == 0 && mem_valid == 0, "R1 reset", {done_o, irq_o, 23'd0, mem_valid}, 0);
    rst_n = 1'b1;
    pause(2);

    // Sweep: offsets, inner and outer counts (R2 R3 R4 R5 R8 R12)
    ncase = 0;
    for (int si = 0; si < 3; si++)
      for (int di = 0; di < 2; di++)
        for (int mi = 1; mi <= 3; mi++)
          for (int ma = 1; ma <= 2; ma++) begin
            int so, dof, ch;
            so  = (si == 0) ? 1 : (si == 1) ? 2 : -1;
            dof = (di == 0) ? 1 : -1;
            ch  = ncase % NCH;
            ncase++;
            for (int a = 144; a < 192; a++) mem[a] = 32'd0;
            prog(ch, {16'h00A0, 16'h0040}, w1f(so, dof, mi, ma), 32'd0);
            for (int k = 0; k < ma; k++) begin
              check(done_o[ch] == 1'b0, "R8 early", 32'(done_o[ch]), 0);
              w0c = wcnt;
              kick(NCH'(1) << ch);
              pause(80);
              check(wcnt - w0c == mi, "R3 R4 count", 32'(wcnt - w0c), 32'(mi));
            end
            for (int t = 0; t < mi * ma; t++) begin
              sa = (64 + t * so) & 255;
              da = (160 + t * dof) & 255;
              check(mem[da] == pat(sa), "R2 R12 data", mem[da], pat(sa));
            end
            check(done_o[ch] == 1'b1, "R8 done", 32'(done_o[ch]), 1);
            check(irq_o[ch] == 1'b0, "R8 noirq", 32'(irq_o[ch]), 0);
            a0 = acnt;
            kick(NCH'(1) << ch);
            pause(40);
            check(acnt == a0, "R5 idle", 32'(acnt), 32'(a0));
            clear(ch);
            check(done_o[ch] == 1'b0, "R8 clear", 32'(done_o[ch]), 0);
          end

    // Interrupt (R8)
    prog(2, {16'h00C0, 16'h0010}, w1f(1, 1, 1, 1), 32'h4000_0000);
    kick(4'b0100);
    pause(60);
    check(irq_o[2] && done_o[2], "R8 irq", {30'd0, irq_o[2], done_o[2]}, 3);
    clear(2);
    check(!irq_o[2] && !done_o[2], "R8 irq clear", {30'd0, irq_o[2], done_o[2]}, 0);

    // Fixed priority (R6)
    rr_mode = 1'b0;
    for (int c = 0; c < NCH; c++) prog(c, {16'h00C0 + 16'(c), 16'h0010 + 16'(c)}, w1f(1, 1, 1, 1), 32'd0);
    wcnt = 0;
    kick(4'b1111);
    pause(200);
    for (int j = 0; j < NCH; j++)
      check(wlog[j] == 8'(8'hC0 + 3 - j), "R6 order", 32'(wlog[j]), 32'(8'hC0 + 3 - j));
    exp_last = 0;

    // Round robin (R7)
    rr_mode = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      prog(c, {16'h00C0 + 16'(c), 16'h0010 + 16'(c)}, w1f(1, 1, 1, 1), 32'd0);
      clear(c);
    end
    wcnt = 0;
    kick(4'b1111);
    pause(200);
    for (int j = 0; j < NCH; j++)
      check(wlog[j] == 8'(8'hC0 + ((exp_last + 1 + j) % NCH)), "R7 order", 32'(wlog[j]),
            32'(8'hC0 + ((exp_last + 1 + j) % NCH)));
    exp_last = (exp_last + NCH) % NCH;
    prog(0, {16'h00C0, 16'h0010}, w1f(1, 1, 1, 1), 32'd0);
    prog(2, {16'h00C2, 16'h0012}, w1f(1, 1, 1, 1), 32'd0);
    wcnt = 0;
    kick(4'b0101);
    pause(120);
    check(wlog[0] == 8'hC2 && wlog[1] == 8'hC0, "R7 skip", {wlog[0], wlog[1]}, 16'hC2C0);

    // No preemption (R13)
    rr_mode = 1'b0;
    prog(0, {16'h00D0, 16'h0020}, w1f(1, 1, 3, 1), 32'd0);
    prog(3, {16'h00D8, 16'h0030}, w1f(1, 1, 1, 1), 32'd0);
    wcnt = 0;
    kick(4'b0001);
    pause(2);
    kick(4'b1000);
    pause(150);
    check(wcnt == 4 && wlog[0] == 8'hD0 && wlog[1] == 8'hD1 && wlog[2] == 8'hD2 && wlog[3] == 8'hD8,
          "R13 order", {wlog[0], wlog[1], wlog[2], wlog[3]}, 32'hD0D1D2D8);

    // Inner-end link (R9)
    for (int c = 0; c < NCH; c++) clear(c);
    prog(1, {16'h00E0, 16'h0011}, w1f(1, 1, 1, 2), 32'h1002_0000);
    prog(2, {16'h00E8, 16'h0012}, w1f(1, 1, 1, 3), 32'd0);
    wcnt = 0;
    kick(4'b0010);
    pause(120);
    check(wcnt == 2 && wlog[1] == 8'hE8, "R9 link", {wcnt[7:0], wlog[1]}, 16'h02E8);
    kick(4'b0010);
    pause(120);
    check(wcnt == 3 && wlog[2] == 8'hE1, "R10 no inner link at end", {wcnt[7:0], wlog[2]}, 16'h03E1);
    check(done_o[1] && !done_o[2], "R9 done", {30'd0, done_o[1], done_o[2]}, 2);

    // Outer-end link (R10)
    prog(1, {16'h00E0, 16'h0011}, w1f(1, 1, 1, 1), 32'h3003_0000);
    prog(3, {16'h00EC, 16'h0013}, w1f(1, 1, 1, 1), 32'd0);
    wcnt = 0;
    kick(4'b0010);
    pause(120);
    check(wcnt == 2 && wlog[1] == 8'hEC, "R10 link", {wcnt[7:0], wlog[1]}, 16'h02EC);

    // Scatter/gather (R11)
    mem[248] = {16'h00B8, 16'h0020};
    mem[249] = w1f(1, 1, 2, 1);
    mem[250] = 32'd0;
    prog(0, {16'h00B0, 16'h0015}, w1f(1, 1, 1, 1), 32'h8000_00F8);
    wcnt = 0;
    kick(4'b0001);
    pause(120);
    check(wcnt == 1 && mem[176] == pat(21), "R11 first", mem[176], pat(21));
    kick(4'b0001);
    pause(120);
    check(wcnt == 3 && mem[184] == pat(32) && mem[185] == pat(33), "R11 reload", mem[185], pat(33));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule